// File: doc/BRIEF.md
# Static Memory Write Cycle Controller with Ready-Style Wait

This block runs one write transfer at a time to an external asynchronous static memory or peripheral. A host raises a request carrying an address, a 16-bit data word, two byte enables and three timing counts: setup, pulse and hold. When the controller is idle it latches all of these and runs the bus cycle. Chip select goes low for the whole access. The write strobe goes low only for the pulse phase. Address, data and byte selects stay driven from the first setup cycle to the last hold cycle.

The external device can stretch the access with an active-low wait line, used in a ready style. The line is brought into the clock domain by a two-flop synchroniser. Its synchronised value is looked at only in the final cycle of the write-strobe pulse. If wait is active then, the access freezes: the strobe stays low and every bus output keeps its value. The access resumes with the hold phase once the synchronised wait goes inactive. Wait activity at any other point in the access does not change its length. When the hold phase ends, the controller returns to idle and pulses its acknowledge for one cycle.

Top module: `smcw_write_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, the outputs are idle. `mem_cs_n`=1, `mem_we_n`=1, `mem_be_n`=2'b11, `mem_dq_oe`=0 and `req_ack`=0.
- R2: A request is taken only in a cycle where `mem_cs_n`=1 (idle). Address, data and byte enables are latched at that edge and stay unchanged on the bus for the whole access. Requests made during an access are ignored. `mem_be_n` is the inverse of the latched `req_be` (bit 0 is the low byte).
- R3: `mem_cs_n` and `mem_dq_oe` become active in the first cycle after the accepting edge. A setup phase of `cfg_setup` cycles follows, with the strobe high. A setup count of 0 skips this phase.
- R4: `mem_we_n` is low for max(`cfg_pulse`,1) cycles, so a pulse count of 0 gives one cycle. It is only ever low while `mem_cs_n` is low.
- R5: `mem_wait_n` passes through two flip-flops before the control logic uses it. The value seen in cycle t is the pin value that was sampled at the edge ending cycle t-2.
- R6: If the synchronised wait is active in the last pulse cycle, the access freezes. `mem_we_n` stays low and the bus outputs hold their values until a cycle in which the synchronised wait is inactive. That cycle is the last low cycle of the strobe.
- R7: Wait that is active only before the last pulse cycle, or only after the pulse has ended (as seen through the synchroniser), does not change the access length.
- R8: After the pulse (including any freeze), a hold phase of `cfg_hold` cycles follows. During hold, `mem_cs_n` is low, `mem_we_n` is high and data is driven. A hold count of 0 skips this phase.
- R9: `req_ack` is high for exactly one cycle per access: the first idle cycle after the access. `mem_cs_n` is high in that cycle.
- R10: A synchronous reset during an access ends it. The outputs are idle from the next cycle, and the next request runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host write request |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables, active high |
| cfg_setup | input | CNT_W | Setup cycles |
| cfg_pulse | input | CNT_W | Strobe pulse cycles (0 counts as 1) |
| cfg_hold | input | CNT_W | Hold cycles |
| req_ack | output | 1 | One-cycle completion pulse |
| mem_wait_n | input | 1 | External wait, active low, asynchronous |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_be_n | output | DATA_W/8 | Byte selects, active low |
| mem_addr | output | ADDR_W | Address bus |
| mem_dq | output | DATA_W | Data bus value |
| mem_dq_oe | output | 1 | Data bus drive enable |

## Verification
Chip select and data drive are due one cycle after the accepting edge. The strobe falls `cfg_setup` cycles later. The pin value of wait reaches the decision two edges after it is sampled. The acknowledge is due in the cycle after the last hold cycle. A behavioural model in the bench counts cycles from the accepting edge and carries its own picture of the two-edge wait delay. Every output is compared with the model at each falling clock edge, half a period away from the edges that change it. For each access, the bench also totals the strobe-low cycles, the select-low cycles and the acknowledge pulses, and checks them against counts worked out by hand from the wait timing it drove.

// File: rtl/smcw_pkg.sv
package smcw_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_FROZEN,
        PH_HOLD
    } phase_e;

endpackage

// File: rtl/smcw_wait_sync.sv
module smcw_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wait_n_raw,
    output logic wait_act
);

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], wait_n_raw};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= sh_d;
    end

    assign wait_act = ~sh_q[STAGES-1];

    generate
        if (STAGES == 2) begin : g_lag_chk
            // R5: synchronised wait equals the pin two edges back
            a_r5_sync_lag: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !$past(rst, 2)) |-> (wait_act == !$past(wait_n_raw, 2)));
        end
    endgenerate

endmodule

// File: rtl/smcw_bus_latch.sv
module smcw_bus_latch #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    localparam int BE_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic [BE_W-1:0]   in_be,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic [BE_W-1:0]   be_q
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } bus_s;

    bus_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (accept) begin
            r_d.addr = in_addr;
            r_d.data = in_data;
            r_d.be   = in_be;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign addr_q = r_q.addr;
    assign data_q = r_q.data;
    assign be_q   = r_q.be;

endmodule

// File: rtl/smcw_phase_seq.sv
module smcw_phase_seq
    import smcw_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [CNT_W-1:0] cfg_setup,
    input  logic [CNT_W-1:0] cfg_pulse,
    input  logic [CNT_W-1:0] cfg_hold,
    input  logic             wait_act,
    output logic             accept,
    output phase_e           phase,
    output logic             ack
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] pulse_len;
        logic [CNT_W-1:0] hold_len;
        logic             ack;
    } seq_s;

    seq_s s_d, s_q;
    logic [CNT_W-1:0] pulse_eff;

    assign pulse_eff = (cfg_pulse == '0) ? ONE : cfg_pulse;

    always_comb begin
        s_d     = s_q;
        s_d.ack = 1'b0;
        accept  = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    accept        = 1'b1;
                    s_d.pulse_len = pulse_eff;
                    s_d.hold_len  = cfg_hold;
                    if (cfg_setup != '0) begin
                        s_d.ph  = PH_SETUP;
                        s_d.cnt = cfg_setup;
                    end else begin
                        s_d.ph  = PH_PULSE;
                        s_d.cnt = pulse_eff;
                    end
                end
            end
            PH_SETUP: begin
                if (s_q.cnt == ONE) begin
                    s_d.ph  = PH_PULSE;
                    s_d.cnt = s_q.pulse_len;
                end else begin
                    s_d.cnt = s_q.cnt - ONE;
                end
            end
            PH_PULSE, PH_FROZEN: begin
                if (s_q.ph == PH_PULSE && s_q.cnt != ONE) begin
                    s_d.cnt = s_q.cnt - ONE;
                end else if (wait_act) begin
                    s_d.ph = PH_FROZEN;
                end else if (s_q.hold_len != '0) begin
                    s_d.ph  = PH_HOLD;
                    s_d.cnt = s_q.hold_len;
                end else begin
                    s_d.ph  = PH_IDLE;
                    s_d.ack = 1'b1;
                end
            end
            PH_HOLD: begin
                if (s_q.cnt == ONE) begin
                    s_d.ph  = PH_IDLE;
                    s_d.ack = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - ONE;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q    <= '0;
            s_q.ph <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase = s_q.ph;
    assign ack   = s_q.ack;

    // R6: an active wait keeps a frozen access frozen
    a_r6_freeze_holds: assert property (@(posedge clk) disable iff (rst)
        (s_q.ph == PH_FROZEN && wait_act) |=> (s_q.ph == PH_FROZEN));

    // R7: freezing is entered only from the strobe phase
    a_r7_no_freeze_elsewhere: assert property (@(posedge clk) disable iff (rst)
        (s_q.ph != PH_PULSE && s_q.ph != PH_FROZEN) |=> (s_q.ph != PH_FROZEN));

    // R9: acknowledge lasts one cycle
    a_r9_ack_single: assert property (@(posedge clk) disable iff (rst)
        s_q.ack |=> !s_q.ack);

endmodule

// File: rtl/smcw_write_ctrl.sv
module smcw_write_ctrl
    import smcw_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int DATA_W      = 16,
    parameter int CNT_W       = 6,
    parameter int SYNC_STAGES = 2,
    localparam int BE_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [BE_W-1:0]   req_be,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_pulse,
    input  logic [CNT_W-1:0]  cfg_hold,
    output logic              req_ack,
    input  logic              mem_wait_n,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic [BE_W-1:0]   mem_be_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq,
    output logic              mem_dq_oe
);

    logic              wait_act;
    logic              accept;
    phase_e            phase;
    logic [BE_W-1:0]   be_q;
    logic              busy;

    smcw_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .wait_n_raw (mem_wait_n),
        .wait_act   (wait_act)
    );

    smcw_phase_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .cfg_setup (cfg_setup),
        .cfg_pulse (cfg_pulse),
        .cfg_hold  (cfg_hold),
        .wait_act  (wait_act),
        .accept    (accept),
        .phase     (phase),
        .ack       (req_ack)
    );

    smcw_bus_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .in_addr (req_addr),
        .in_data (req_data),
        .in_be   (req_be),
        .addr_q  (mem_addr),
        .data_q  (mem_dq),
        .be_q    (be_q)
    );

    assign busy      = (phase != PH_IDLE);
    assign mem_cs_n  = ~busy;
    assign mem_dq_oe = busy;
    assign mem_we_n  = ~((phase == PH_PULSE) || (phase == PH_FROZEN));
    assign mem_be_n  = busy ? ~be_q : '1;

    // R4: strobe only inside chip select
    a_r4_we_in_cs: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_cs_n);

    // R9: acknowledge comes with the bus idle
    a_r9_ack_idle: assert property (@(posedge clk) disable iff (rst)
        req_ack |-> mem_cs_n);

    // R2: bus values stay put across a running access
    a_r2_bus_stable: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |->
            ($stable(mem_addr) && $stable(mem_dq) && $stable(mem_be_n)));

endmodule

// File: tb/smcw_write_ctrl_test.sv
module smcw_write_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic [1:0]  req_be = '0;
    logic [5:0]  cfg_setup = '0, cfg_pulse = '0, cfg_hold = '0;
    logic        mem_wait_n = 1'b1;
    logic        req_ack, mem_cs_n, mem_we_n, mem_dq_oe;
    logic [1:0]  mem_be_n;
    logic [23:0] mem_addr;
    logic [15:0] mem_dq;

    int checks = 0;
    int errors = 0;

    smcw_write_ctrl uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_be(req_be), .cfg_setup(cfg_setup),
        .cfg_pulse(cfg_pulse), .cfg_hold(cfg_hold), .req_ack(req_ack),
        .mem_wait_n(mem_wait_n), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq(mem_dq),
        .mem_dq_oe(mem_dq_oe)
    );

    always #4 clk = ~clk;

    // behavioural reference: cycles since acceptance plus freeze extension
    int   m_busy = 0, m_t = 0, m_ext = 0, m_s = 0, m_pe = 1, m_h = 0;
    logic m_ack = 1'b0, m_w1 = 1'b1, m_w2 = 1'b1;
    logic [23:0] m_addr = '0;
    logic [15:0] m_data = '0;
    logic [1:0]  m_be = '0;
    bit   started = 0;

    always @(posedge clk) begin
        started <= 1;
        if (rst) begin
            m_busy = 0; m_ack = 1'b0; m_w1 = 1'b1; m_w2 = 1'b1;
        end else begin
            m_ack = 1'b0;
            if (m_busy != 0) begin
                if (m_t == m_s + m_pe - 1 + m_ext && m_w2 == 1'b0) m_ext++;
                m_t++;
                if (m_t == m_s + m_pe + m_ext + m_h) begin
                    m_busy = 0; m_ack = 1'b1;
                end
            end else if (req_valid) begin
                m_busy = 1; m_t = 0; m_ext = 0;
                m_s = int'(cfg_setup);
                m_pe = (cfg_pulse == 0) ? 1 : int'(cfg_pulse);
                m_h = int'(cfg_hold);
                m_addr = req_addr; m_data = req_data; m_be = req_be;
            end
            m_w2 = m_w1; m_w1 = mem_wait_n;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            logic  e_we;
            string ph;
            e_we = (m_busy != 0) && (m_t >= m_s) && (m_t < m_s + m_pe + m_ext);
            if (m_busy == 0)            ph = "R1";
            else if (m_t < m_s)         ph = "R3";
            else if (m_t < m_s + m_pe)  ph = "R4";
            else if (e_we)              ph = "R6";
            else                        ph = "R8";
            check(mem_cs_n == (m_busy == 0), ph, "cs_n", int'(mem_cs_n), int'(m_busy == 0));
            check(mem_dq_oe == (m_busy != 0), ph, "dq_oe", int'(mem_dq_oe), int'(m_busy != 0));
            check(mem_we_n == !e_we, ph, "we_n", int'(mem_we_n), int'(!e_we));
            check(req_ack == m_ack, "R9", "ack", int'(req_ack), int'(m_ack));
            if (m_busy != 0) begin
                check(mem_addr == m_addr && mem_dq == m_data, "R2", "addr/data",
                      int'(mem_addr), int'(m_addr));
                check(mem_be_n == ~m_be, "R2", "be_n", int'(mem_be_n), int'(~m_be));
            end else begin
                check(mem_be_n == 2'b11, "R1", "be_n idle", int'(mem_be_n), 3);
            end
        end
    end

    // one access; wait pin low for access cycles [wf,wt); request held kr cycles
    task automatic run_access(input int s, input int p, input int h,
                              input logic [23:0] a, input logic [15:0] d,
                              input logic [1:0] be, input int wf, input int wt,
                              input int kr, input int exp_we, input int exp_len,
                              input string req);
        int we_cnt = 0, cs_cnt = 0, acks = 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_data = d; req_be = be;
        cfg_setup = 6'(s); cfg_pulse = 6'(p); cfg_hold = 6'(h);
        for (int t = 0; t < 200; t++) begin
            @(negedge clk);
            req_valid  = (t < kr);
            req_addr   = ~a;
            req_data   = ~d;
            mem_wait_n = !(t >= wf && t < wt);
            if (!mem_we_n) we_cnt++;
            if (!mem_cs_n) cs_cnt++;
            if (req_ack) begin acks++; break; end
        end
        mem_wait_n = 1'b1;
        req_valid  = 1'b0;
        check(we_cnt == exp_we, req, "strobe-low cycles", we_cnt, exp_we);
        check(cs_cnt == exp_len, req, "select-low cycles", cs_cnt, exp_len);
        check(acks == 1, "R9", "ack pulses", acks, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(mem_cs_n && mem_we_n && !mem_dq_oe && !req_ack && mem_be_n == 2'b11,
              "R1", "reset outputs", int'({mem_cs_n, mem_we_n, mem_dq_oe, req_ack}), 12);
        rst = 1'b0;
        @(negedge clk);
        check(mem_cs_n && !req_ack, "R1", "idle after reset", int'(mem_cs_n), 1);

        run_access(2, 5, 2, 24'h12_3456, 16'hBEEF, 2'b11, 0, 0, 0, 5, 9, "R3");
        run_access(0, 0, 0, 24'h00_0001, 16'h0001, 2'b01, 0, 0, 0, 1, 1, "R4");
        run_access(2, 5, 2, 24'hAB_CDEF, 16'h1234, 2'b10, 0, 9, 0, 10, 14, "R6");
        run_access(2, 5, 2, 24'h00_0F0F, 16'h5A5A, 2'b11, 6, 7, 0, 5, 9, "R5");
        run_access(2, 5, 2, 24'h00_F0F0, 16'hA5A5, 2'b11, 4, 5, 0, 6, 10, "R5");
        run_access(2, 5, 2, 24'h11_1111, 16'h2222, 2'b01, 0, 3, 0, 5, 9, "R7");
        run_access(2, 5, 2, 24'h33_3333, 16'h4444, 2'b10, 7, 12, 0, 5, 9, "R7");
        run_access(1, 3, 4, 24'h55_5555, 16'h6666, 2'b11, 0, 0, 4, 3, 8, "R2");
        run_access(3, 1, 0, 24'h77_7777, 16'h8888, 2'b11, 0, 3, 0, 3, 6, "R8");
        run_access(0, 2, 3, 24'h99_9999, 16'hAAAA, 2'b01, 0, 0, 0, 2, 5, "R8");

        // R10: reset in the middle of an access
        @(negedge clk);
        req_valid = 1'b1; cfg_setup = 6'd2; cfg_pulse = 6'd5; cfg_hold = 6'd2;
        req_addr = 24'hCC_CCCC; req_data = 16'hDDDD; req_be = 2'b11;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(!mem_we_n, "R10", "strobe active before reset", int'(mem_we_n), 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(mem_cs_n && mem_we_n && !mem_dq_oe, "R10", "idle after mid-access reset",
              int'({mem_cs_n, mem_we_n, mem_dq_oe}), 6);
        run_access(1, 2, 1, 24'hEE_EEEE, 16'hFFFF, 2'b10, 0, 0, 0, 2, 4, "R10");

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule